// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR flash device. It watches the stream of bus write cycles (address plus data) and turns keyed multi-write sequences into single-cycle requests for the embedded program/erase engine that sits beside it. The request types are: program with address and data, chip erase, sector erase with a sector number, erase suspend and erase resume. The array itself, the algorithm timing and the status bits belong to other blocks.

The decoder also keeps the device mode. It can be in normal array reading, in identification (autoselect) reading, or in the unlock-bypass mode. In unlock-bypass mode a program takes two writes instead of four. Separately, it tracks whether a sector erase is running and whether that erase is suspended. While identification mode is active, it drives the manufacturer code, the device code and the per-sector protection flag for the read address presented to it. Addressing can be word-wide or byte-wide. The keyed unlock addresses depend on that choice.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, the mode output is 0 (array read), erase_suspended is 0, id_valid is 0 and every request pulse is 0.
- R2: The keyed prefix is data AAh at the first key address, then 55h at the second key address. The key addresses are 555h/2AAh (address bits 10:0) in word mode and AAAh/555h (bits 11:0) in byte mode. Any write that breaks the expected step drops the sequence and issues nothing.
- R3: A program request follows the prefix and A0h at the first key address. The next write is taken whole as target address and data, even when its data is F0h or B0h. pgm_go is high for the cycle after that write and carries that address and the full data word.
- R4: A chip erase needs the prefix, 80h at the first key address, the prefix again, and then 10h at the first key address. chip_erase_go pulses after the last write.
- R5: In the same six-write chain, a last write of 30h at any address pulses sect_erase_go. erase_sect is set to address bits 17:12 in word mode and to bits 18:13 in byte mode.
- R6: The prefix followed by 90h at the first key address sets mode 1 (identification) and id_valid. The read offset is taken from rd_addr bits 10:0 in word mode and bits 11:0 in byte mode. Offset 0 reads 01h. Offset 1 (word) or 2 (byte) reads the device code. Offset 2 (word) or 4 (byte) reads 01h for a protected sector and 00h otherwise. Any other offset reads 00h. In mode 1, every write except F0h is ignored.
- R7: The prefix followed by 20h at the first key address sets mode 2 (bypass). In mode 2, A0h and then one write issue a program, and 90h then 00h return the mode to 0. Key addresses are not checked in mode 2.
- R8: A write of F0h at any address, outside a program data step, drops any partial sequence. It returns mode 1 to mode 0 and leaves mode 2 unchanged.
- R9: B0h at any address pulses suspend_go and sets erase_suspended, but only while a sector erase is in progress and not already suspended. It is accepted even while busy is high. A sector erase counts as in progress from its request until busy falls while the erase is not suspended.
- R10: While suspended, 30h written with no sequence pending pulses resume_go and clears erase_suspended.
- R11: While suspended, program and identification entry work as usual, but 80h and 20h after the prefix are dropped.
- R12: While busy is high, every write other than an honoured B0h is ignored and the sequence position is kept.
- R13: Data bits 15:8 and the address bits above the key field do not affect unlock or command cycles.
- R14: Request pulses last one cycle, and at most one is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_mode | input | 1 | 1 selects byte addressing, 0 word addressing |
| busy | input | 1 | Embedded operation running |
| wr_en | input | 1 | One bus write this cycle |
| wr_addr | input | 19 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 19 | Read address for identification data |
| sect_prot | input | 64 | Protection flag per sector |
| pgm_go | output | 1 | Program request pulse |
| pgm_addr | output | 19 | Program target address |
| pgm_data | output | 16 | Program data |
| chip_erase_go | output | 1 | Chip erase request pulse |
| sect_erase_go | output | 1 | Sector erase request pulse |
| erase_sect | output | 6 | Sector to erase |
| suspend_go | output | 1 | Erase suspend request pulse |
| resume_go | output | 1 | Erase resume request pulse |
| mode | output | 2 | 0 array read, 1 identification, 2 bypass |
| erase_suspended | output | 1 | Sector erase is suspended |
| id_valid | output | 1 | Identification data is being driven |
| id_data | output | 8 | Identification read data |

## Verification
The program sequence is driven in word mode, in byte mode, and with high address and data bits set. Together these separate correct key-field masking from matching on the full bus. A broken prefix and a prefix at the wrong key address show that aborts issue nothing. The suspend path is exercised with B0h both inside and outside a running sector erase, and with 30h both as a resume and as an erase-chain terminator. This tells the erase-state gate apart from plain data decoding. Identification reads are made at protected and unprotected sectors in both addressing modes, and the writes ignored in identification and bypass modes are checked through the mode output.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [1:0] {
        MD_READ    = 2'd0,
        MD_AUTOSEL = 2'd1,
        MD_BYPASS  = 2'd2
    } mode_e;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_KEY1, SQ_KEY2, SQ_PGM,
        SQ_ER_KEY1, SQ_ER_KEY2, SQ_ER_LAST,
        SQ_BYP_PGM, SQ_BYP_EXIT
    } seq_e;

    typedef struct packed {
        logic first;
        logic second;
    } key_hit_t;

    typedef struct packed {
        logic pgm;
        logic chip;
        logic sect;
        logic susp;
        logic resume;
    } cmd_t;

    localparam logic [7:0] CD_KEY_A   = 8'hAA;
    localparam logic [7:0] CD_KEY_B   = 8'h55;
    localparam logic [7:0] CD_IDENT   = 8'h90;
    localparam logic [7:0] CD_PROGRAM = 8'hA0;
    localparam logic [7:0] CD_BYPASS  = 8'h20;
    localparam logic [7:0] CD_ER_SET  = 8'h80;
    localparam logic [7:0] CD_CHIP    = 8'h10;
    localparam logic [7:0] CD_SECTOR  = 8'h30;
    localparam logic [7:0] CD_RESUME  = 8'h30;
    localparam logic [7:0] CD_RESET   = 8'hF0;
    localparam logic [7:0] CD_SUSPEND = 8'hB0;
    localparam logic [7:0] CD_BYP_OUT = 8'h00;
    localparam logic [7:0] MFR_CODE   = 8'h01;

endpackage

// File: rtl/fcd_addr_decode.sv
module fcd_addr_decode import fcd_pkg::*; #(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              byte_mode,
    output key_hit_t          hit,
    output logic [SECT_W-1:0] sect
);
    always_comb begin
        if (byte_mode) begin
            hit.first  = (addr[11:0] == 12'hAAA);
            hit.second = (addr[11:0] == 12'h555);
            sect       = addr[ADDR_W-1 -: SECT_W];
        end else begin
            hit.first  = (addr[10:0] == 11'h555);
            hit.second = (addr[10:0] == 11'h2AA);
            sect       = addr[ADDR_W-2 -: SECT_W];
        end
    end
endmodule

// File: rtl/fcd_id_read.sv
module fcd_id_read import fcd_pkg::*; #(
    parameter int         ADDR_W   = 19,
    parameter int         SECT_W   = 6,
    parameter logic [7:0] DEV_CODE = 8'hC4,
    localparam int        NUM_SECT = 1 << SECT_W
) (
    input  logic                active,
    input  logic                byte_mode,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [NUM_SECT-1:0] sect_prot,
    output logic [7:0]          id_data
);
    logic [SECT_W-1:0] rd_sect;
    logic [11:0]       off;
    logic              prot;

    always_comb begin
        rd_sect = byte_mode ? rd_addr[ADDR_W-1 -: SECT_W] : rd_addr[ADDR_W-2 -: SECT_W];
        off     = byte_mode ? rd_addr[11:0] : {1'b0, rd_addr[10:0]};
        prot    = sect_prot[rd_sect];
        id_data = 8'h00;
        if (active) begin
            if (off == 12'd0)
                id_data = MFR_CODE;
            else if (off == (byte_mode ? 12'd2 : 12'd1))
                id_data = DEV_CODE;
            else if (off == (byte_mode ? 12'd4 : 12'd2))
                id_data = {7'd0, prot};
        end
    end
endmodule

// File: rtl/fcd_erase_track.sv
module fcd_erase_track (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic start_sect,
    input  logic do_susp,
    input  logic do_resume,
    output logic erase_run,
    output logic suspended
);
    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            erase_run <= 1'b0;
            suspended <= 1'b0;
        end else begin
            busy_q <= busy;
            if (start_sect)
                erase_run <= 1'b1;
            else if (busy_q && !busy && !suspended)
                erase_run <= 1'b0;
            if (do_susp)
                suspended <= 1'b1;
            else if (do_resume)
                suspended <= 1'b0;
        end
    end

    // R9: suspend only granted for a running, unsuspended sector erase
    p_susp_gate_r9: assert property (@(posedge clk) disable iff (rst)
        do_susp |-> (erase_run && !suspended));

    // R10: resume only granted while suspended
    p_resume_gate_r10: assert property (@(posedge clk) disable iff (rst)
        do_resume |-> suspended);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder import fcd_pkg::*; #(
    parameter int         ADDR_W   = 19,
    parameter int         DATA_W   = 16,
    parameter int         SECT_W   = 6,
    parameter logic [7:0] DEV_CODE = 8'hC4,
    localparam int        NUM_SECT = 1 << SECT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                byte_mode,
    input  logic                busy,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [NUM_SECT-1:0] sect_prot,
    output logic                pgm_go,
    output logic [ADDR_W-1:0]   pgm_addr,
    output logic [DATA_W-1:0]   pgm_data,
    output logic                chip_erase_go,
    output logic                sect_erase_go,
    output logic [SECT_W-1:0]   erase_sect,
    output logic                suspend_go,
    output logic                resume_go,
    output logic [1:0]          mode,
    output logic                erase_suspended,
    output logic                id_valid,
    output logic [7:0]          id_data
);
    seq_e              seq_q, seq_n;
    mode_e             mode_q, mode_n;
    cmd_t              cmd_q, cmd_n;
    key_hit_t          hit;
    logic [SECT_W-1:0] wr_sect;
    logic              erase_run, suspended;
    logic [7:0]        d8;

    fcd_addr_decode #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_dec (
        .addr(wr_addr), .byte_mode(byte_mode), .hit(hit), .sect(wr_sect));

    fcd_erase_track u_trk (
        .clk(clk), .rst(rst), .busy(busy),
        .start_sect(cmd_n.sect), .do_susp(cmd_n.susp), .do_resume(cmd_n.resume),
        .erase_run(erase_run), .suspended(suspended));

    fcd_id_read #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .DEV_CODE(DEV_CODE)) u_id (
        .active(mode_q == MD_AUTOSEL), .byte_mode(byte_mode),
        .rd_addr(rd_addr), .sect_prot(sect_prot), .id_data(id_data));

    always_comb begin
        seq_n  = seq_q;
        mode_n = mode_q;
        cmd_n  = '0;
        d8     = wr_data[7:0];
        if (wr_en) begin
            if (d8 == CD_SUSPEND && erase_run && !suspended &&
                seq_q != SQ_PGM && seq_q != SQ_BYP_PGM) begin
                cmd_n.susp = 1'b1;
                seq_n      = SQ_IDLE;
            end else if (!busy) begin
                if (seq_q == SQ_PGM || seq_q == SQ_BYP_PGM) begin
                    cmd_n.pgm = 1'b1;
                    seq_n     = SQ_IDLE;
                end else if (mode_q == MD_AUTOSEL) begin
                    if (d8 == CD_RESET) mode_n = MD_READ;
                    seq_n = SQ_IDLE;
                end else if (d8 == CD_RESET) begin
                    seq_n = SQ_IDLE;
                end else if (suspended && seq_q == SQ_IDLE && d8 == CD_RESUME) begin
                    cmd_n.resume = 1'b1;
                end else if (mode_q == MD_BYPASS) begin
                    seq_n = SQ_IDLE;
                    if (seq_q == SQ_IDLE && d8 == CD_PROGRAM)
                        seq_n = SQ_BYP_PGM;
                    else if (seq_q == SQ_IDLE && d8 == CD_IDENT)
                        seq_n = SQ_BYP_EXIT;
                    else if (seq_q == SQ_BYP_EXIT && d8 == CD_BYP_OUT)
                        mode_n = MD_READ;
                end else begin
                    seq_n = SQ_IDLE;
                    unique case (seq_q)
                        SQ_IDLE:    if (hit.first && d8 == CD_KEY_A)  seq_n = SQ_KEY1;
                        SQ_KEY1:    if (hit.second && d8 == CD_KEY_B) seq_n = SQ_KEY2;
                        SQ_KEY2: if (hit.first) begin
                            if (d8 == CD_IDENT)                      mode_n = MD_AUTOSEL;
                            else if (d8 == CD_PROGRAM)               seq_n  = SQ_PGM;
                            else if (d8 == CD_BYPASS && !suspended)  mode_n = MD_BYPASS;
                            else if (d8 == CD_ER_SET && !suspended)  seq_n  = SQ_ER_KEY1;
                        end
                        SQ_ER_KEY1: if (hit.first && d8 == CD_KEY_A)  seq_n = SQ_ER_KEY2;
                        SQ_ER_KEY2: if (hit.second && d8 == CD_KEY_B) seq_n = SQ_ER_LAST;
                        SQ_ER_LAST: begin
                            if (hit.first && d8 == CD_CHIP) cmd_n.chip = 1'b1;
                            else if (d8 == CD_SECTOR)        cmd_n.sect = 1'b1;
                        end
                        default: seq_n = SQ_IDLE;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q      <= SQ_IDLE;
            mode_q     <= MD_READ;
            cmd_q      <= '0;
            pgm_addr   <= '0;
            pgm_data   <= '0;
            erase_sect <= '0;
        end else begin
            seq_q  <= seq_n;
            mode_q <= mode_n;
            cmd_q  <= cmd_n;
            if (cmd_n.pgm) begin
                pgm_addr <= wr_addr;
                pgm_data <= wr_data;
            end
            if (cmd_n.sect) erase_sect <= wr_sect;
        end
    end

    assign pgm_go          = cmd_q.pgm;
    assign chip_erase_go   = cmd_q.chip;
    assign sect_erase_go   = cmd_q.sect;
    assign suspend_go      = cmd_q.susp;
    assign resume_go       = cmd_q.resume;
    assign mode            = mode_q;
    assign erase_suspended = suspended;
    assign id_valid        = (mode_q == MD_AUTOSEL);

    // R14: never two requests in one cycle
    p_one_request_r14: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pgm_go, chip_erase_go, sect_erase_go, suspend_go, resume_go}));

    // R14: a program request never lasts two cycles
    p_pgm_single_r14: assert property (@(posedge clk) disable iff (rst)
        pgm_go |=> !pgm_go);

    // R12: only suspend may be granted from a write made while busy
    p_busy_gate_r12: assert property (@(posedge clk) disable iff (rst)
        (pgm_go || chip_erase_go || sect_erase_go || resume_go) |-> !$past(busy));

    // R6: leaving identification mode needs an F0h write
    p_ident_exit_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MD_AUTOSEL && $past(mode_q == MD_AUTOSEL)) |->
        $past(wr_en && wr_data[7:0] == CD_RESET));

    // R7: leaving bypass mode needs a 00h write
    p_bypass_exit_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MD_BYPASS && $past(mode_q == MD_BYPASS)) |->
        $past(wr_en && wr_data[7:0] == CD_BYP_OUT));
endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst = 1'b1, byte_mode = 1'b0, busy = 1'b0, wr_en = 1'b0;
    logic [18:0] wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic [63:0] sect_prot = 64'h1 << 43;
    logic        pgm_go, chip_erase_go, sect_erase_go, suspend_go, resume_go;
    logic        erase_suspended, id_valid;
    logic [18:0] pgm_addr;
    logic [15:0] pgm_data;
    logic [5:0]  erase_sect;
    logic [1:0]  mode;
    logic [7:0]  id_data;

    int checks = 0, fails = 0;
    bit cmp_en = 0;

    flash_cmd_decoder dut_i (
        .clk(clk), .rst(rst), .byte_mode(byte_mode), .busy(busy), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .sect_prot(sect_prot),
        .pgm_go(pgm_go), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .chip_erase_go(chip_erase_go), .sect_erase_go(sect_erase_go),
        .erase_sect(erase_sect), .suspend_go(suspend_go), .resume_go(resume_go),
        .mode(mode), .erase_suspended(erase_suspended), .id_valid(id_valid),
        .id_data(id_data));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: step numbers 0 idle, 1/2 keys seen, 3 program data,
    // 4/5 erase keys, 6 erase final, 7 bypass program data, 8 bypass exit.
    int          m_mode = 0, m_step = 0;
    bit          m_run = 0, m_susp = 0, m_bq = 0;
    bit          e_pgm = 0, e_chip = 0, e_sect = 0, e_susp = 0, e_res = 0;
    logic [18:0] e_paddr = '0;
    logic [15:0] e_pdata = '0;
    logic [5:0]  e_sec = '0;

    always @(posedge clk) begin
        bit k1, k2;
        logic [7:0] d;
        e_pgm = 0; e_chip = 0; e_sect = 0; e_susp = 0; e_res = 0;
        if (rst) begin
            m_mode = 0; m_step = 0; m_run = 0; m_susp = 0; m_bq = 0;
            e_paddr = '0; e_pdata = '0; e_sec = '0;
        end else begin
            d  = wr_data[7:0];
            k1 = byte_mode ? ((wr_addr & 19'hFFF) == 19'hAAA) : ((wr_addr & 19'h7FF) == 19'h555);
            k2 = byte_mode ? ((wr_addr & 19'hFFF) == 19'h555) : ((wr_addr & 19'h7FF) == 19'h2AA);
            if (wr_en) begin
                if (d == 8'hB0 && m_run && !m_susp && m_step != 3 && m_step != 7) begin
                    e_susp = 1; m_step = 0;
                end else if (!busy) begin
                    if (m_step == 3 || m_step == 7) begin
                        e_pgm = 1; e_paddr = wr_addr; e_pdata = wr_data; m_step = 0;
                    end else if (m_mode == 1) begin
                        if (d == 8'hF0) m_mode = 0;
                        m_step = 0;
                    end else if (d == 8'hF0) m_step = 0;
                    else if (m_susp && m_step == 0 && d == 8'h30) e_res = 1;
                    else if (m_mode == 2) begin
                        if (m_step == 0 && d == 8'hA0) m_step = 7;
                        else if (m_step == 0 && d == 8'h90) m_step = 8;
                        else begin
                            if (m_step == 8 && d == 8'h00) m_mode = 0;
                            m_step = 0;
                        end
                    end else begin
                        case (m_step)
                            0: m_step = (k1 && d == 8'hAA) ? 1 : 0;
                            1: m_step = (k2 && d == 8'h55) ? 2 : 0;
                            2: begin
                                m_step = 0;
                                if (k1 && d == 8'h90) m_mode = 1;
                                else if (k1 && d == 8'hA0) m_step = 3;
                                else if (k1 && d == 8'h20 && !m_susp) m_mode = 2;
                                else if (k1 && d == 8'h80 && !m_susp) m_step = 4;
                            end
                            4: m_step = (k1 && d == 8'hAA) ? 5 : 0;
                            5: m_step = (k2 && d == 8'h55) ? 6 : 0;
                            6: begin
                                m_step = 0;
                                if (k1 && d == 8'h10) e_chip = 1;
                                else if (d == 8'h30) begin
                                    e_sect = 1;
                                    e_sec  = byte_mode ? 6'(wr_addr >> 13) : 6'(wr_addr >> 12);
                                end
                            end
                            default: m_step = 0;
                        endcase
                    end
                end
            end
            if (e_sect) m_run = 1;
            else if (m_bq && !busy && !m_susp) m_run = 0;
            if (e_susp) m_susp = 1;
            else if (e_res) m_susp = 0;
            m_bq = busy;
        end
    end

    function automatic logic [7:0] exp_id();
        logic [11:0] off;
        int sec;
        if (m_mode != 1) return 8'h00;
        off = byte_mode ? rd_addr[11:0] : {1'b0, rd_addr[10:0]};
        sec = byte_mode ? int'(rd_addr >> 13) : int'((rd_addr >> 12) & 19'h3F);
        if (off == 0) return 8'h01;
        if (off == (byte_mode ? 12'd2 : 12'd1)) return 8'hC4;
        if (off == (byte_mode ? 12'd4 : 12'd2)) return {7'd0, sect_prot[sec]};
        return 8'h00;
    endfunction

    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R3 pgm_go", pgm_go, e_pgm);
            if (e_pgm) begin
                chk("R3 pgm_addr", pgm_addr, e_paddr);
                chk("R3 pgm_data", pgm_data, e_pdata);
            end
            chk("R4 chip_erase_go", chip_erase_go, e_chip);
            chk("R5 sect_erase_go", sect_erase_go, e_sect);
            if (e_sect) chk("R5 erase_sect", erase_sect, e_sec);
            chk("R9 suspend_go", suspend_go, e_susp);
            chk("R10 resume_go", resume_go, e_res);
            chk("R9 erase_suspended", erase_suspended, m_susp);
            chk("R8 mode", mode, m_mode);
            chk("R6 id_valid", id_valid, m_mode == 1);
            chk("R6 id_data", id_data, exp_id());
        end
    end

    task automatic wr(input logic [18:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
    endtask

    task automatic prefix_w();
        wr(19'h555, 16'h00AA); wr(19'h2AA, 16'h0055);
    endtask

    task automatic prefix_b();
        wr(19'hAAA, 16'h00AA); wr(19'h555, 16'h0055);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog R1-all actual=hang expected=done");
        finish_run();
    end

    initial begin
        idle(3);
        @(negedge clk); #1; rst = 1'b0; cmp_en = 1;
        idle(1);
        // R1 reset state
        chk("R1 mode", mode, 0);
        chk("R1 erase_suspended", erase_suspended, 0);
        chk("R1 id_valid", id_valid, 0);
        chk("R1 pgm_go", pgm_go, 0);

        // R3 word program
        prefix_w(); wr(19'h555, 16'h00A0); wr(19'h01234, 16'hBEEF);
        chk("R3 pgm_go", pgm_go, 1);
        chk("R3 pgm_addr", pgm_addr, 19'h01234);
        chk("R3 pgm_data", pgm_data, 16'hBEEF);
        idle(1);
        chk("R14 pgm one cycle", pgm_go, 0);

        // R2 wrong key address aborts
        wr(19'h556, 16'h00AA); wr(19'h2AA, 16'h0055); wr(19'h555, 16'h00A0); wr(19'h00100, 16'h0055);
        chk("R2 abort no pgm", pgm_go, 0);

        // R2 byte-mode keys, R3 data F0h as program data
        byte_mode = 1'b1;
        prefix_b(); wr(19'hAAA, 16'h00A0); wr(19'h20001, 16'h00F0);
        chk("R2 byte program", pgm_go, 1);
        chk("R3 F0 data kept", pgm_data, 16'h00F0);

        // R13 high address and data bits ignored
        byte_mode = 1'b0;
        wr(19'h3F555, 16'hFFAA); wr(19'h122AA, 16'h1255); wr(19'h40555, 16'h77A0); wr(19'h00042, 16'h1111);
        chk("R13 masked program", pgm_go, 1);

        // R4 chip erase
        prefix_w(); wr(19'h555, 16'h0080); prefix_w(); wr(19'h555, 16'h0010);
        chk("R4 chip erase", chip_erase_go, 1);

        // R5 sector erase, byte mode
        byte_mode = 1'b1;
        prefix_b(); wr(19'hAAA, 16'h0080); prefix_b(); wr(19'h56000, 16'h0030);
        chk("R5 sect_erase_go", sect_erase_go, 1);
        chk("R5 erase_sect", erase_sect, 6'h2B);
        byte_mode = 1'b0;
        busy = 1'b1;

        // R12 writes ignored while busy
        prefix_w(); wr(19'h555, 16'h0090);
        chk("R12 busy ignores", mode, 0);
        // R9 suspend while busy
        wr(19'h07000, 16'h00B0);
        chk("R9 suspend_go", suspend_go, 1);
        idle(1);
        busy = 1'b0;
        idle(2);
        chk("R9 still suspended", erase_suspended, 1);

        // R11 erase setup refused while suspended
        prefix_w(); wr(19'h555, 16'h0080); prefix_w(); wr(19'h555, 16'h0030);
        chk("R11 no sector erase", sect_erase_go, 0);
        chk("R11 no resume", erase_suspended, 1);
        prefix_w(); wr(19'h555, 16'h00A0); wr(19'h00777, 16'h4321);
        chk("R11 program in suspend", pgm_go, 1);

        // R6 identification reads
        prefix_w(); wr(19'h555, 16'h0090);
        chk("R6 mode ident", mode, 1);
        rd_addr = 19'h00000; #2; chk("R6 mfr", id_data, 8'h01);
        rd_addr = 19'h00001; #2; chk("R6 dev", id_data, 8'hC4);
        rd_addr = 19'h2B002; #2; chk("R6 protected", id_data, 8'h01);
        rd_addr = 19'h05002; #2; chk("R6 unprotected", id_data, 8'h00);
        byte_mode = 1'b1;
        rd_addr = 19'h56004; #2; chk("R6 byte protected", id_data, 8'h01);
        rd_addr = 19'h00002; #2; chk("R6 byte dev", id_data, 8'hC4);
        byte_mode = 1'b0;
        wr(19'h00000, 16'h0030);
        chk("R6 30h ignored", resume_go, 0);
        wr(19'h00000, 16'h00F0);
        chk("R8 exit ident", mode, 0);

        // R10 resume, then erase completes
        wr(19'h12345, 16'h0030);
        chk("R10 resume_go", resume_go, 1);
        busy = 1'b1; idle(2); busy = 1'b0; idle(2);
        wr(19'h00000, 16'h00B0);
        chk("R9 no suspend after done", suspend_go, 0);

        // R7 bypass
        prefix_w(); wr(19'h555, 16'h0020);
        chk("R7 bypass mode", mode, 2);
        wr(19'h00000, 16'h00A0); wr(19'h00321, 16'h5A5A);
        chk("R7 bypass program", pgm_go, 1);
        wr(19'h00000, 16'h0055);
        wr(19'h00000, 16'h00F0);
        chk("R8 F0 keeps bypass", mode, 2);
        wr(19'h00000, 16'h0090); wr(19'h00000, 16'h0000);
        chk("R7 bypass exit", mode, 0);

        idle(3);
        finish_run();
    end
endmodule